// File: doc/BRIEF.md
# Halfword-Read Receive Word Queue

This block holds up to 32 received 32-bit words for one receive channel and hands them to a host over a 16-bit read bus. Words that upstream logic has already accepted arrive on a single-cycle write strobe and join the tail of the queue. The host reads the oldest word as two halves. It pulls an active-low enable down with the halfword select low to get the first half, then with the select high to get the second half. When it releases the enable after the second half, the word leaves the queue.

Two active-low flags report the queue state. One shows that at least one word is waiting. The other shows that all 32 slots are taken. A control input picks between two layouts of the word on the bus. The straight layout puts bits 15..0 in the first half. The label-reversed layout mirrors the 8-bit label field that sits in the low byte.

Top module: `rxq_halfword_reader`

## Requirements
- R1: After reset, ready_n and full_n are 1, bus_oe is 0 and bus_data is 0.
- R2: A word presented with wr_valid=1 at a clock edge where fewer than 32 words are held is stored. From that edge on, ready_n is 0.
- R3: full_n is 0 exactly while 32 words are held. ready_n stays 0 while any word is held and returns to 1 only once the queue is empty.
- R4: A write at an edge where 32 words are held is dropped. The held words and their order stay unchanged.
- R5: While rd_en_n is 1, bus_oe is 0 and bus_data is all zeros, whatever hsel or order_sel are.
- R6: While rd_en_n is 0, bus_oe is 1 in the same cycle. With hsel=0 the bus carries the first half of the oldest word. With hsel=1 it carries the second half, which is always word bits 31..16.
- R7: With order_sel=0 the first half is word bits 15..0. With order_sel=1 the first half keeps bits 15..8 as word bits 15..8, and first-half bit i equals word bit 7-i for i in 0..7.
- R8: The oldest word is removed at the first clock edge that sees rd_en_n=1 after a low interval whose last low cycle had hsel=1. A low interval that ends with hsel=0 removes nothing. Words come out in write order.
- R9: A read with the queue empty drives bus_oe=1 with bus_data all zeros and removes nothing.
- R10: When a removal and a write fall on the same edge and fewer than 32 words are held, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe for an accepted word |
| wr_word | input | 32 | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| hsel | input | 1 | Halfword select: 0 first half, 1 second half |
| order_sel | input | 1 | Bus layout: 0 straight, 1 label reversed |
| bus_data | output | 16 | Read bus, zero when released |
| bus_oe | output | 1 | High while the bus is driven |
| ready_n | output | 1 | Low while at least one word is held |
| full_n | output | 1 | Low while 32 words are held |

## Verification
Bus contents and bus_oe follow rd_en_n, hsel and order_sel within the same cycle. The bench therefore samples them 1 ns after the negative edge on which it changed those inputs. Writes and removals land on the next rising edge, and the flags come from a registered fill count, so flag checks wait for the following negative edge. The release cycle ends a read. In that cycle the bench checks the idle bus and applies any concurrent write. The bench's queue model is updated only after the rising edge that carries out the removal.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned LABEL_W = 8;

  typedef enum logic {
    ORD_STRAIGHT = 1'b0,
    ORD_LABEL_REV = 1'b1
  } order_e;

  function automatic logic [HALF_W-1:0] upper_half(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:HALF_W];
  endfunction

  function automatic logic next_is_full(input int unsigned fill, input int unsigned depth);
    return fill == depth;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              pop,
  output logic              wr_acc,
  output logic [WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]  fill
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr_acc    = wr_valid && (fill != CNT_W'(DEPTH));
  assign head_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_acc) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      case ({wr_acc, pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/rxq_read_seq.sv
module rxq_read_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en_n,
  input  logic hsel,
  input  logic empty,
  output logic pop_evt
);
  logic en_n_q;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_q <= 1'b1;
      sel_q  <= 1'b0;
    end else begin
      en_n_q <= rd_en_n;
      if (!rd_en_n) sel_q <= hsel;
    end
  end

  assign pop_evt = rd_en_n && !en_n_q && sel_q && !empty;
endmodule

// File: rtl/rxq_half_map.sv
module rxq_half_map
  import rxq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              order_sel,
  output logic [HALF_W-1:0] lo_half,
  output logic [HALF_W-1:0] hi_half
);
  logic [LABEL_W-1:0] label_rev;

  for (genvar i = 0; i < LABEL_W; i++) begin : g_rev
    assign label_rev[i] = word[LABEL_W-1-i];
  end

  always_comb begin
    lo_half = word[HALF_W-1:0];
    if (order_e'(order_sel) == ORD_LABEL_REV) lo_half[LABEL_W-1:0] = label_rev;
  end

  assign hi_half = upper_half(word);
endmodule

// File: rtl/rxq_halfword_reader.sv
module rxq_halfword_reader
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en_n,
  input  logic              hsel,
  input  logic              order_sel,
  output logic [HALF_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              ready_n,
  output logic              full_n
);
  logic              wr_acc;
  logic              pop_evt;
  logic              empty;
  logic [WORD_W-1:0] head_word;
  logic [CNT_W-1:0]  fill;
  logic [HALF_W-1:0] lo_half, hi_half;

  rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .pop(pop_evt), .wr_acc(wr_acc), .head_word(head_word), .fill(fill)
  );

  rxq_read_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .hsel(hsel),
    .empty(empty), .pop_evt(pop_evt)
  );

  rxq_half_map u_map (
    .word(head_word), .order_sel(order_sel),
    .lo_half(lo_half), .hi_half(hi_half)
  );

  assign empty    = (fill == '0);
  assign ready_n  = empty;
  assign full_n   = !next_is_full(int'(fill), DEPTH);
  assign bus_oe   = !rd_en_n;
  assign bus_data = (!rd_en_n && !empty) ? (hsel ? hi_half : lo_half) : '0;
endmodule

// File: rtl/rxq_halfword_reader_chk.sv
module rxq_halfword_reader_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en_n,
  input logic             wr_valid,
  input logic [15:0]      bus_data,
  input logic             bus_oe,
  input logic             ready_n,
  input logic             full_n,
  input logic             pop_evt,
  input logic             wr_acc,
  input logic [CNT_W-1:0] fill
);
  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |-> (bus_data == '0 && !bus_oe));

  p_full_implies_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !ready_n);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_valid && !pop_evt) |=> $stable(fill));

  p_ready_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !ready_n);

  p_pop_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> rd_en_n);

  p_pop_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !wr_acc) |=> (fill == $past(fill) - 1'b1));

  p_both_hold_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && wr_acc) |=> $stable(fill));
endmodule

bind rxq_halfword_reader rxq_halfword_reader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .wr_valid(wr_valid),
  .bus_data(bus_data), .bus_oe(bus_oe), .ready_n(ready_n), .full_n(full_n),
  .pop_evt(pop_evt), .wr_acc(wr_acc), .fill(fill)
);

// File: tb/rxq_halfword_reader_tb.sv
`timescale 1ns/1ps
module rxq_halfword_reader_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_valid = 0;
  logic [31:0] wr_word = 0;
  logic        rd_en_n = 1;
  logic        hsel = 0;
  logic        order_sel = 0;
  logic [15:0] bus_data;
  logic        bus_oe, ready_n, full_n;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  logic [31:0] q[$];

  always #2.5 clk = ~clk;

  rxq_halfword_reader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .rd_en_n(rd_en_n), .hsel(hsel), .order_sel(order_sel),
    .bus_data(bus_data), .bus_oe(bus_oe), .ready_n(ready_n), .full_n(full_n)
  );

  function automatic logic [15:0] exp_half(input logic [31:0] w, input logic ord, input logic sel);
    logic [15:0] r;
    if (sel) return w[31:16];
    r = w[15:0];
    if (ord) for (int i = 0; i < 8; i++) r[i] = w[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " ready_n"}, {31'd0, ready_n}, {31'd0, q.size() == 0});
    chk({req, " full_n"}, {31'd0, full_n}, {31'd0, q.size() != 32});
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1; wr_word = w;
    @(posedge clk);
    if (q.size() < 32) q.push_back(w);
    @(negedge clk);
    wr_valid = 0;
    #1 chk_flags("R2/R3/R4 after write");
  endtask

  // full read when do_pop, first half only otherwise; optional write on release
  task automatic read_word(input logic ord, input logic do_pop, input logic wr_too, input logic [31:0] wv);
    logic [31:0] head;
    logic        was_full;
    head = (q.size() > 0) ? q[0] : 32'h0;
    @(negedge clk);
    order_sel = ord; rd_en_n = 0; hsel = 0;
    #1;
    chk("R6 oe", {31'd0, bus_oe}, 32'd1);
    chk(q.size() == 0 ? "R9 empty lo" : "R6/R7 lo half", {16'd0, bus_data},
        {16'd0, q.size() == 0 ? 16'h0 : exp_half(head, ord, 1'b0)});
    if (do_pop) begin
      @(negedge clk);
      hsel = 1;
      #1 chk(q.size() == 0 ? "R9 empty hi" : "R6 hi half", {16'd0, bus_data},
             {16'd0, q.size() == 0 ? 16'h0 : exp_half(head, ord, 1'b1)});
    end
    @(negedge clk);
    rd_en_n = 1; hsel = 0;
    if (wr_too) begin wr_valid = 1; wr_word = wv; end
    #1;
    chk("R5 released data", {16'd0, bus_data}, 32'd0);
    chk("R5 released oe", {31'd0, bus_oe}, 32'd0);
    @(posedge clk);
    was_full = (q.size() == 32);
    if (do_pop && q.size() > 0) void'(q.pop_front());
    if (wr_too && !was_full) q.push_back(wv);
    @(negedge clk);
    wr_valid = 0;
    #1 chk_flags("R8/R10 after read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    #1;
    chk("R1 ready_n", {31'd0, ready_n}, 32'd1);
    chk("R1 full_n", {31'd0, full_n}, 32'd1);
    chk("R1 oe", {31'd0, bus_oe}, 32'd0);
    chk("R1 data", {16'd0, bus_data}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R9: read from empty queue
    read_word(1'b0, 1'b1, 1'b0, 32'h0);

    // R7: label reversal on a known pattern
    write_word(32'hA5C3_1E01);
    read_word(1'b1, 1'b0, 1'b0, 32'h0);
    chk("R7 label reversed", {16'd0, exp_half(32'hA5C3_1E01, 1'b1, 1'b0)}, 32'h0000_1E80);
    // R8: first-half-only read did not remove the word
    read_word(1'b0, 1'b1, 1'b0, 32'h0);

    // R3/R4: fill to full, overflow attempts dropped
    for (int i = 0; i < 32; i++) write_word(32'h1000_0000 + i * 32'h0101_0101);
    chk("R3 full_n at 32", {31'd0, full_n}, 32'd0);
    write_word(32'hDEAD_BEEF);
    write_word(32'hFEED_F00D);
    // R4: pop with concurrent write while full drops the write
    read_word(1'b1, 1'b1, 1'b1, 32'hBAD0_BAD0);
    // R10: pop with concurrent write when not full
    read_word(1'b0, 1'b1, 1'b1, 32'h7777_0042);
    while (q.size() > 0) read_word(q.size() % 2, 1'b1, 1'b0, 32'h0);
    chk("R3 ready_n empty", {31'd0, ready_n}, 32'd1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 4) write_word($urandom);
      else if (r < 8) read_word(1'($urandom), 1'b1, 1'b0, 32'h0);
      else if (r < 9) read_word(1'($urandom), 1'b0, 1'b0, 32'h0);
      else read_word(1'($urandom), 1'b1, 1'b1, $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule